// File: doc/BRIEF.md
# Dual-Mode Transmit Packet Sequencer

This block builds the outbound word sequence toward a host link. A control side asks for one of two transfer kinds. A register transfer sends three tagged words: a request, the target address, and the write value. A streaming transfer sends a request that holds the word count, then the destination address, then the given number of data words. The stream words are taken one by one from a valid/ready source.

Every output word carries a 2-bit type tag. Words leave on a valid/ready interface. A link-status input pauses emission at once when it drops. Emission picks up at the same word when the link returns, so no word is lost or sent twice.

A register request that arrives while a stream burst is running is held. It is sent as soon as the burst has finished.

Top module: `pkt_seq_tx`

## Requirements
- R1: The tag on `out_tag_o` encodes the word type: 00 request, 01 address, 10 register content, 11 stream data. Every transfer starts with a word tagged 00.
- R2: A register transfer emits three words in this order, then the block goes idle: a request whose data is all zero, an address word with `ord_addr_i` zero-extended, and a content word equal to `ord_data_i`.
- R3: A streaming transfer first emits a request word, then an address word with `dma_addr_i` zero-extended. In the request word, bit DW-1 is set and the low CW bits hold the programmed length `dma_len_i`.
- R4: After the address word, exactly `dma_len_i` stream words follow, in the order the source delivered them, and the block then goes idle. A length of zero goes idle right after the address word.
- R5: A pulse on `ord_req_i` during a stream burst is held. The register transfer starts after the last stream word has been sent.
- R6: While `link_up_i` is low, `out_valid_o` and `s_ready_o` are low. The sequence position does not change, and a non-stream word on the output holds its tag and data. When the link returns, emission resumes with no word lost.
- R7: While `out_ready_i` is low, a pending non-stream word holds its tag and data.
- R8: `dma_start_i` is ignored while the block is busy or a register request is pending. A second `ord_req_i` is ignored while one is already pending.
- R9: After reset, `out_valid_o`, `s_ready_o` and `busy_o` are low.
- R10: `s_ready_o` is high only in the stream phase. A stream word is emitted only while `s_valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | Link status; low pauses emission |
| ord_req_i | input | 1 | Pulse requesting a register transfer |
| ord_addr_i | input | AW | Register target address |
| ord_data_i | input | DW | Register write content |
| dma_start_i | input | 1 | Pulse starting a streaming transfer |
| dma_addr_i | input | AW | Stream destination address |
| dma_len_i | input | CW | Stream word count |
| s_valid_i | input | 1 | Stream source word valid |
| s_data_i | input | DW | Stream source word |
| s_ready_o | output | 1 | Stream word accepted this cycle when valid |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Output word accepted by link side |
| out_tag_o | output | 2 | Word type tag |
| out_data_o | output | DW | Word payload |
| busy_o | output | 1 | A transfer is in progress |

## Verification
The assertions check the following on every cycle:
- a dropped link keeps valid and ready low;
- a non-stream word holds still under link loss or back-pressure;
- ready appears only in the stream phase;
- every transfer opens with a request;
- an idle block never asserts valid;
- a register address word is followed by a content word.

Only the bench scenarios can show the rest:
- the full word order and payloads;
- the exact stream word count, including zero;
- a register request deferred across a burst;
- start pulses that are dropped while the block is busy;
- loss-free resumption after the link returns.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;
  typedef enum logic [1:0] {
    TAG_REQ    = 2'b00,
    TAG_ADDR   = 2'b01,
    TAG_CONT   = 2'b10,
    TAG_STREAM = 2'b11
  } pkt_tag_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ    = 3'd1,
    ST_ADDR   = 3'd2,
    ST_CONT   = 3'd3,
    ST_STREAM = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pkt_seq_ord_hold.sv
module pkt_seq_ord_hold #(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          done_i,
  output logic          pend_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic          pend_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  // capture only when empty; clear once the content word leaves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (done_i) begin
      pend_q <= 1'b0;
    end else if (req_i && !pend_q) begin
      pend_q <= 1'b1;
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign pend_o = pend_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/pkt_seq_burst_cnt.sv
module pkt_seq_burst_cnt #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= len_i;
    else if (dec_i)  cnt_q <= cnt_q - CW'(1);
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/pkt_seq_fsm.sv
module pkt_seq_fsm
  import pkt_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       link_up_i,
  input  logic       pend_i,
  input  logic       dma_start_i,
  input  logic       out_ready_i,
  input  logic       s_valid_i,
  input  logic       cnt_zero_i,
  input  logic       cnt_last_i,
  output seq_state_e state_o,
  output logic       dma_o,
  output logic       accept_dma_o,
  output logic       ord_done_o,
  output logic       cnt_dec_o,
  output logic       out_valid_o,
  output logic       s_ready_o
);
  seq_state_e state_q, state_d;
  logic       dma_q, dma_d;
  logic       fire;

  always_comb begin
    out_valid_o = 1'b0;
    if (link_up_i) begin
      unique case (state_q)
        ST_REQ, ST_ADDR, ST_CONT: out_valid_o = 1'b1;
        ST_STREAM:                out_valid_o = s_valid_i;
        default:                  out_valid_o = 1'b0;
      endcase
    end
  end

  assign fire         = out_valid_o && out_ready_i;
  assign s_ready_o    = link_up_i && out_ready_i && (state_q == ST_STREAM);
  assign cnt_dec_o    = fire && (state_q == ST_STREAM);
  // a held register request wins over a new stream start
  assign accept_dma_o = (state_q == ST_IDLE) && !pend_i && dma_start_i;
  assign ord_done_o   = fire && (state_q == ST_CONT);

  always_comb begin
    state_d = state_q;
    dma_d   = dma_q;
    unique case (state_q)
      ST_IDLE: begin
        if (pend_i) begin
          state_d = ST_REQ;
          dma_d   = 1'b0;
        end else if (dma_start_i) begin
          state_d = ST_REQ;
          dma_d   = 1'b1;
        end
      end
      ST_REQ:  if (fire) state_d = ST_ADDR;
      ST_ADDR: if (fire) state_d = !dma_q ? ST_CONT : (cnt_zero_i ? ST_IDLE : ST_STREAM);
      ST_CONT: if (fire) state_d = ST_IDLE;
      ST_STREAM: if (fire && cnt_last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dma_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dma_q   <= dma_d;
    end
  end

  assign state_o = state_q;
  assign dma_o   = dma_q;
endmodule

// File: rtl/pkt_seq_tx.sv
module pkt_seq_tx
  import pkt_seq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          link_up_i,
  input  logic          ord_req_i,
  input  logic [AW-1:0] ord_addr_i,
  input  logic [DW-1:0] ord_data_i,
  input  logic          dma_start_i,
  input  logic [AW-1:0] dma_addr_i,
  input  logic [CW-1:0] dma_len_i,
  input  logic          s_valid_i,
  input  logic [DW-1:0] s_data_i,
  output logic          s_ready_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [1:0]    out_tag_o,
  output logic [DW-1:0] out_data_o,
  output logic          busy_o
);
  seq_state_e    state_q;
  logic          dma_q;
  logic          accept_dma, ord_done, cnt_dec;
  logic          pend;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;
  logic [CW-1:0] cnt;
  logic          cnt_zero, cnt_last;
  logic [AW-1:0] dma_addr_q;
  logic [DW-1:0] req_word;

  pkt_seq_ord_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (ord_req_i),
    .addr_i (ord_addr_i),
    .data_i (ord_data_i),
    .done_i (ord_done),
    .pend_o (pend),
    .addr_o (pend_addr),
    .data_o (pend_data)
  );

  pkt_seq_burst_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept_dma),
    .len_i  (dma_len_i),
    .dec_i  (cnt_dec),
    .cnt_o  (cnt),
    .zero_o (cnt_zero),
    .last_o (cnt_last)
  );

  pkt_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .link_up_i    (link_up_i),
    .pend_i       (pend),
    .dma_start_i  (dma_start_i),
    .out_ready_i  (out_ready_i),
    .s_valid_i    (s_valid_i),
    .cnt_zero_i   (cnt_zero),
    .cnt_last_i   (cnt_last),
    .state_o      (state_q),
    .dma_o        (dma_q),
    .accept_dma_o (accept_dma),
    .ord_done_o   (ord_done),
    .cnt_dec_o    (cnt_dec),
    .out_valid_o  (out_valid_o),
    .s_ready_o    (s_ready_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         dma_addr_q <= '0;
    else if (accept_dma) dma_addr_q <= dma_addr_i;
  end

  // stream request: top bit flags stream mode, low bits carry the length
  always_comb begin
    req_word = '0;
    if (dma_q) begin
      req_word[CW-1:0] = cnt;
      req_word[DW-1]   = 1'b1;
    end
  end

  always_comb begin
    out_tag_o  = TAG_REQ;
    out_data_o = '0;
    unique case (state_q)
      ST_REQ: begin
        out_tag_o  = TAG_REQ;
        out_data_o = req_word;
      end
      ST_ADDR: begin
        out_tag_o  = TAG_ADDR;
        out_data_o = dma_q ? DW'(dma_addr_q) : DW'(pend_addr);
      end
      ST_CONT: begin
        out_tag_o  = TAG_CONT;
        out_data_o = pend_data;
      end
      ST_STREAM: begin
        out_tag_o  = TAG_STREAM;
        out_data_o = s_data_i;
      end
      default: ;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/pkt_seq_tx_chk.sv
module pkt_seq_tx_chk
  import pkt_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          link_up_i,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic          s_ready_o,
  input logic          busy_o,
  input logic [1:0]    out_tag_o,
  input logic [DW-1:0] out_data_o,
  input logic [2:0]    state_q,
  input logic          dma_q
);
  a_r6_link_down_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_i |-> (!out_valid_o && !s_ready_o));

  a_r6_hold_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_up_i && busy_o && out_tag_o != TAG_STREAM)
      |=> ($stable(out_tag_o) && $stable(out_data_o)));

  a_r7_hold_backpressure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && out_tag_o != TAG_STREAM)
      |=> ($stable(out_tag_o) && $stable(out_data_o)));

  a_r10_ready_stream_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> (busy_o && out_tag_o == TAG_STREAM));

  a_r1_first_is_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (out_tag_o == TAG_REQ));

  a_r9_idle_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !out_valid_o);

  a_r2_cont_follows_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && state_q == 3'(ST_ADDR) && !dma_q)
      |=> (state_q == 3'(ST_CONT)));
endmodule

bind pkt_seq_tx pkt_seq_tx_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .link_up_i   (link_up_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .s_ready_o   (s_ready_o),
  .busy_o      (busy_o),
  .out_tag_o   (out_tag_o),
  .out_data_o  (out_data_o),
  .state_q     (state_q),
  .dma_q       (dma_q)
);

// File: tb/sim_pkt_seq_tx.sv
`timescale 1ns/1ps
module sim_pkt_seq_tx;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          link_up = 1'b1;
  logic          ord_req = 1'b0;
  logic [AW-1:0] ord_addr = '0;
  logic [DW-1:0] ord_data = '0;
  logic          dma_start = 1'b0;
  logic [AW-1:0] dma_addr = '0;
  logic [CW-1:0] dma_len = '0;
  logic          s_valid;
  logic [DW-1:0] s_data;
  logic          s_ready;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1:0]    out_tag;
  logic [DW-1:0] out_data;
  logic          busy;

  int nchk = 0;
  int nerr = 0;

  logic          src_on = 1'b0;
  logic          gap_en = 1'b0;
  int            src_idx = 0;
  int            cyc = 0;
  logic [1:0]    cap_tag [256];
  logic [DW-1:0] cap_data [256];
  int            cap_n = 0;

  always #5 clk = ~clk;

  assign s_valid = src_on && !(gap_en && (cyc % 3 == 0));
  assign s_data  = 32'hA000_0000 + DW'(src_idx);

  pkt_seq_tx #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .link_up_i(link_up),
    .ord_req_i(ord_req), .ord_addr_i(ord_addr), .ord_data_i(ord_data),
    .dma_start_i(dma_start), .dma_addr_i(dma_addr), .dma_len_i(dma_len),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_tag_o(out_tag), .out_data_o(out_data), .busy_o(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (s_valid && s_ready) src_idx <= src_idx + 1;
    if (rst_n && out_valid && out_ready && cap_n < 256) begin
      cap_tag[cap_n]  <= out_tag;
      cap_data[cap_n] <= out_data;
      cap_n <= cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_word(input int idx, input logic [1:0] tag, input logic [DW-1:0] data, input string req);
    chk(cap_tag[idx] == tag, {req, " tag"}, DW'(cap_tag[idx]), DW'(tag));
    chk(cap_data[idx] == data, {req, " data"}, cap_data[idx], data);
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 400 && quiet < 4; i++) begin
      @(negedge clk);
      if (!busy) quiet++; else quiet = 0;
    end
  endtask

  task automatic send_ord(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ord_req = 1'b1; ord_addr = a; ord_data = d;
    @(negedge clk);
    ord_req = 1'b0;
  endtask

  task automatic send_dma(input logic [AW-1:0] a, input logic [CW-1:0] n);
    @(negedge clk);
    dma_start = 1'b1; dma_addr = a; dma_len = n;
    @(negedge clk);
    dma_start = 1'b0;
  endtask

  task automatic t_reset();
    chk(!out_valid, "R9 valid", DW'(out_valid), 0);
    chk(!s_ready, "R9 s_ready", DW'(s_ready), 0);
    chk(!busy, "R9 busy", DW'(busy), 0);
  endtask

  task automatic t_ordinary();
    int b = cap_n;
    send_ord(24'h12_3456, 32'hDEAD_BEEF);
    wait_idle();
    chk(cap_n - b == 3, "R2 word count", DW'(cap_n - b), 3);
    expect_word(b,   2'b00, 32'h0, "R1 R2 request");
    expect_word(b+1, 2'b01, 32'h0012_3456, "R2 address");
    expect_word(b+2, 2'b10, 32'hDEAD_BEEF, "R2 content");
  endtask

  task automatic t_dma(input int n, input bit gaps);
    int b = cap_n;
    int sb = src_idx;
    gap_en = gaps;
    src_on = 1'b1;
    send_dma(24'hAB_CD00, CW'(n));
    wait_idle();
    src_on = 1'b0;
    chk(cap_n - b == n + 2, "R4 word count", DW'(cap_n - b), DW'(n + 2));
    expect_word(b,   2'b00, 32'h8000_0000 | DW'(n), "R1 R3 request");
    expect_word(b+1, 2'b01, 32'h00AB_CD00, "R3 address");
    for (int i = 0; i < n; i++)
      expect_word(b+2+i, 2'b11, 32'hA000_0000 + DW'(sb + i), "R4 R10 stream");
    gap_en = 1'b0;
  endtask

  task automatic t_hold_off();
    int b = cap_n;
    int sb = src_idx;
    gap_en = 1'b1;
    src_on = 1'b1;
    send_dma(24'h00_0100, 16'd6);
    repeat (3) @(negedge clk);
    // second start and duplicate register requests must be dropped
    dma_start = 1'b1; dma_addr = 24'h77_7777; dma_len = 16'd9;
    ord_req = 1'b1; ord_addr = 24'h00_0042; ord_data = 32'h1111_2222;
    @(negedge clk);
    dma_start = 1'b0;
    ord_addr = 24'h00_0099; ord_data = 32'h3333_4444;
    @(negedge clk);
    ord_req = 1'b0;
    wait_idle();
    src_on = 1'b0;
    gap_en = 1'b0;
    chk(cap_n - b == 11, "R5 R8 word count", DW'(cap_n - b), 11);
    expect_word(b,   2'b00, 32'h8000_0006, "R5 request");
    expect_word(b+1, 2'b01, 32'h0000_0100, "R5 address");
    for (int i = 0; i < 6; i++)
      expect_word(b+2+i, 2'b11, 32'hA000_0000 + DW'(sb + i), "R5 stream");
    expect_word(b+8,  2'b00, 32'h0, "R5 deferred request");
    expect_word(b+9,  2'b01, 32'h0000_0042, "R5 R8 deferred address");
    expect_word(b+10, 2'b10, 32'h1111_2222, "R5 R8 deferred content");
  endtask

  task automatic t_link();
    int b = cap_n;
    int sb = src_idx;
    link_up = 1'b0;
    send_ord(24'h00_0555, 32'h5555_AAAA);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk(!out_valid, "R6 valid low", DW'(out_valid), 0);
      chk(busy && out_tag == 2'b00, "R6 held request", DW'(out_tag), 0);
      @(negedge clk);
    end
    chk(cap_n == b, "R6 nothing sent", DW'(cap_n - b), 0);
    link_up = 1'b1;
    wait_idle();
    chk(cap_n - b == 3, "R6 ord resumed", DW'(cap_n - b), 3);
    expect_word(b+1, 2'b01, 32'h0000_0555, "R6 address");
    expect_word(b+2, 2'b10, 32'h5555_AAAA, "R6 content");
    b = cap_n;
    src_on = 1'b1;
    send_dma(24'h00_0200, 16'd8);
    repeat (4) @(negedge clk);
    link_up = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!out_valid && !s_ready, "R6 stream paused", DW'({out_valid, s_ready}), 0);
    end
    link_up = 1'b1;
    wait_idle();
    src_on = 1'b0;
    chk(cap_n - b == 10, "R6 stream count", DW'(cap_n - b), 10);
    for (int i = 0; i < 8; i++)
      expect_word(b+2+i, 2'b11, 32'hA000_0000 + DW'(sb + i), "R6 stream order");
  endtask

  task automatic t_backpressure();
    int b = cap_n;
    out_ready = 1'b0;
    send_ord(24'h00_0777, 32'h0BAD_F00D);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk(out_valid && out_tag == 2'b00 && out_data == 0, "R7 held request", out_data, 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    @(negedge clk);
    chk(out_valid && out_tag == 2'b01 && out_data == 32'h0000_0777, "R7 held address", out_data, 32'h0000_0777);
    out_ready = 1'b1;
    wait_idle();
    chk(cap_n - b == 3, "R7 count", DW'(cap_n - b), 3);
    expect_word(b+2, 2'b10, 32'h0BAD_F00D, "R7 content");
  endtask

  task automatic t_ready_idle();
    src_on = 1'b1;
    repeat (3) @(negedge clk);
    chk(!s_ready && !out_valid, "R10 no ready when idle", DW'({s_ready, out_valid}), 0);
    src_on = 1'b0;
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ordinary();
    t_dma(5, 1'b0);
    t_dma(0, 1'b0);
    t_dma(7, 1'b1);
    t_hold_off();
    t_link();
    t_backpressure();
    t_ready_idle();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule